// File: doc/BRIEF.md
# Gated UART Transmit Path

This block is the send side of a serial port. Characters written on a byte-wide port are queued in a small first-in first-out buffer. A shift register drains that buffer one character at a time. Each character is put on a single serial line as an asynchronous frame. A separate bit-rate tick paces the line, so every bit lasts exactly one tick period. The block does not generate that tick.

A transmit-enable bit lives inside the block and can be written through a control strobe. The enable only controls whether the next character may leave the queue and enter the shift register. Clearing it never cuts short the frame on the line. Software or a flow-control agent can therefore pause the stream on a character boundary and resume it later with nothing lost. Writes that arrive while the queue is full are dropped and leave a sticky overflow mark.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `fifo_empty` is 1 and `overflow` is 0.
- R2: The internal transmit enable resets to 1, so a character written after reset is sent with no control write.
- R3: A frame is a 0 start bit, then the 8 data bits with bit 0 first, then a 1 stop bit. `txd` changes only in the cycle after a tick, and each bit stays on the line for one tick period.
- R4: Characters leave in the order they were written. When a further character is queued and the enable is 1, its start bit follows the previous stop bit at the very next tick, with no idle bit between them.
- R5: If the enable is cleared (`ctl_we`=1, `ctl_txen`=0) while a frame is on the line, that frame still completes in full, stop bit included.
- R6: While the enable is 0, no new frame starts. `txd` stays 1 after the current frame, and queued characters stay queued, so `fifo_empty` stays 0.
- R7: Setting the enable back to 1 resumes sending of the queued characters in their original order.
- R8: The queue holds 16 characters. A write while 16 are held is dropped, the stored data are unchanged, and `overflow` becomes 1 and stays 1 until reset.
- R9: `busy` is 1 from the cycle the start bit appears until the end of the stop bit, and 0 whenever the line is idle.
- R10: `fifo_empty` is 1 exactly when no character is waiting in the queue. A character already in the shift register does not count as waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write strobe for a character |
| wr_data | input | 8 | Character to queue |
| ctl_we | input | 1 | Write strobe for the transmit enable |
| ctl_txen | input | 1 | New value of the transmit enable |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |
| fifo_empty | output | 1 | No character waiting |
| overflow | output | 1 | Sticky: a write was dropped on a full queue |

## Verification
A wrong bit index or a bad shift-register load shows up on `txd` within one frame, as a wrong data bit or a missing stop bit at the tick where that bit is due. A fault in the enable gate shows up within one tick after the stop bit: a frame starts while the enable is 0, or a paused queue is drained. Corrupted queue pointers show up as reordered, repeated or lost characters once the queue is resumed. A count off by one shows up at the 16th or 17th write, as an early or missing `overflow`.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Frame = start + data + stop
  function automatic int frame_bits(input int data_w);
    return data_w + 2;
  endfunction
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty_now,
  output logic              empty_q,
  output logic              ovf_q,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, do_push, do_pop;
  logic [CW-1:0]     cnt_next;

  assign full      = (count == CW'(DEPTH));
  assign empty_now = (count == '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty_now;
  assign head      = mem[rd_ptr];

  always_comb begin
    cnt_next = count;
    if (do_push && !do_pop) cnt_next = count + 1'b1;
    else if (do_pop && !do_push) cnt_next = count - 1'b1;
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      empty_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count   <= cnt_next;
      empty_q <= (cnt_next == '0);
      if (push && full) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8,
  localparam int FB    = uart_tx_pkg::frame_bits(DATA_W),
  localparam int IW    = $clog2(FB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              busy,
  output logic              last
);
  logic [FB-1:0] sh;
  logic [IW-1:0] idx;

  assign last = busy && (idx == IW'(FB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      idx  <= '0;
      txd  <= 1'b1;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= {1'b1, load_data, 1'b0};
      idx  <= '0;
      txd  <= 1'b0;
      busy <= 1'b1;
    end else if (tick && busy) begin
      if (last) begin
        busy <= 1'b0;
        txd  <= 1'b1;
        idx  <= '0;
      end else begin
        sh   <= {1'b1, sh[FB-1:1]};
        txd  <= sh[1];
        idx  <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctl_we,
  input  logic              ctl_txen,
  input  logic              bit_tick,
  output logic              txd,
  output logic              busy,
  output logic              fifo_empty,
  output logic              overflow
);
  logic              en_q;
  logic              frame_last, slot_free, start;
  logic              q_empty;
  logic [DATA_W-1:0] q_head;
  logic [CW-1:0]     fifo_cnt;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else if (ctl_we) en_q <= ctl_txen;
  end

  // a new frame may begin at a tick when the line is idle or the stop bit ends
  assign slot_free = !busy || frame_last;
  assign start     = bit_tick && slot_free && en_q && !q_empty;

  uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst),
    .push(wr_valid), .push_data(wr_data),
    .pop(start), .head(q_head),
    .empty_now(q_empty), .empty_q(fifo_empty),
    .ovf_q(overflow), .count(fifo_cnt)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .tick(bit_tick),
    .load(start), .load_data(q_head),
    .txd(txd), .busy(busy), .last(frame_last)
  );
endmodule

// File: rtl/uart_tx_gated_chk.sv
module uart_tx_gated_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_tick,
  input logic          wr_valid,
  input logic          txd,
  input logic          busy,
  input logic          overflow,
  input logic          en_q,
  input logic          frame_last,
  input logic [CW-1:0] fifo_cnt
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  // R9: idle line is high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);

  // R3: line moves only after a tick
  a_r3_tick_paced: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(bit_tick)) |-> $stable(txd));

  // R6: no frame begins while the enable is 0
  a_r6_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(en_q) && !$past(busy)) |-> !busy);

  // R5: a frame is never abandoned before its stop bit ends
  a_r5_no_truncate: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(busy) && !($past(frame_last) && $past(bit_tick))) |-> busy);

  // R8: write on a full queue sets the flag, which then sticks
  a_r8_full_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && fifo_cnt == CW'(DEPTH)) |=> overflow);
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(overflow)) |-> overflow);
endmodule

bind uart_tx_gated uart_tx_gated_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_valid(wr_valid),
  .txd(txd), .busy(busy), .overflow(overflow), .en_q(en_q),
  .frame_last(frame_last), .fifo_cnt(fifo_cnt)
);

// File: tb/uart_tx_gated_tb_top.sv
`timescale 1ns/1ps
module uart_tx_gated_tb_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ctl_we = 1'b0;
  logic       ctl_txen = 1'b0;
  logic       bit_tick = 1'b0;
  logic       txd, busy, fifo_empty, overflow;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_tx_gated dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .ctl_we(ctl_we), .ctl_txen(ctl_txen), .bit_tick(bit_tick),
    .txd(txd), .busy(busy), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  // tick generator plus line decoder, both on the falling edge
  int         div_cnt = 0;
  int         tick_no = 0;
  bit         dec_on = 0;
  int         dec_pos = 0;
  logic [7:0] dec_byte;
  logic [7:0] rx_buf [64];
  int         rx_cnt = 0;
  int         start_tick [64];
  int         frame_err = 0;
  int         busy_err = 0;

  always @(negedge clk) begin
    if (!rst && bit_tick) begin
      tick_no++;
      if (!dec_on) begin
        if (txd == 1'b0) begin
          dec_on = 1; dec_pos = 1;
          if (rx_cnt < 64) start_tick[rx_cnt] = tick_no;
          if (!busy) busy_err++;
        end else if (busy) busy_err++;
      end else begin
        if (!busy) busy_err++;
        if (dec_pos <= 8) begin
          dec_byte[dec_pos-1] = txd;
          dec_pos++;
        end else begin
          if (txd !== 1'b1) frame_err++;
          if (rx_cnt < 64) rx_buf[rx_cnt] = dec_byte;
          rx_cnt++;
          dec_on = 0;
        end
      end
    end
    if (rst) div_cnt = 0;
    else div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
    bit_tick = !rst && (div_cnt == DIV - 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); ctl_we = 1'b1; ctl_txen = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    int guard = 0;
    while (rx_cnt < n && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic wait_ticks(input int n);
    int target = tick_no + n;
    while (tick_no < target) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(fifo_empty == 1'b1, "R1 fifo_empty", fifo_empty, 1);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
  endtask

  task automatic t_single;
    int base = rx_cnt;
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'hA5;
    @(negedge clk); wr_valid = 1'b0;
    chk(fifo_empty == 1'b0, "R10 queued not empty", fifo_empty, 0);
    wait_rx(base + 1);
    chk(rx_cnt == base + 1, "R2 sent after reset enable", rx_cnt, base + 1);
    chk(rx_buf[base] == 8'hA5, "R3 frame data", rx_buf[base], 8'hA5);
    chk(fifo_empty == 1'b1, "R10 drained", fifo_empty, 1);
    wait_ticks(2);
    chk(busy == 1'b0 && txd == 1'b1, "R9 idle after stop", {busy, txd}, 1);
  endtask

  task automatic t_burst;
    int base = rx_cnt;
    logic [7:0] pat [3] = '{8'h00, 8'hFF, 8'h3C};
    for (int i = 0; i < 3; i++) write_byte(pat[i]);
    wait_rx(base + 3);
    for (int i = 0; i < 3; i++)
      chk(rx_buf[base+i] == pat[i], "R4 order", rx_buf[base+i], pat[i]);
    for (int i = 0; i < 2; i++)
      chk(start_tick[base+i+1] - start_tick[base+i] == 10, "R4 back-to-back",
          start_tick[base+i+1] - start_tick[base+i], 10);
  endtask

  task automatic t_gate;
    int base = rx_cnt;
    int guard = 0;
    logic [7:0] pat [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    for (int i = 0; i < 4; i++) write_byte(pat[i]);
    while (!(dec_on && dec_pos >= 4) && guard < 5000) begin @(negedge clk); guard++; end
    set_en(1'b0);
    wait_rx(base + 1);
    chk(rx_cnt == base + 1 && rx_buf[base] == 8'h11, "R5 frame completed",
        rx_buf[base], 8'h11);
    wait_ticks(40);
    chk(rx_cnt == base + 1, "R6 nothing sent while disabled", rx_cnt, base + 1);
    chk(txd == 1'b1 && busy == 1'b0, "R6 line idle", {busy, txd}, 1);
    chk(fifo_empty == 1'b0, "R6 data kept", fifo_empty, 0);
    set_en(1'b1);
    wait_rx(base + 4);
    for (int i = 1; i < 4; i++)
      chk(rx_buf[base+i] == pat[i], "R7 resume order", rx_buf[base+i], pat[i]);
  endtask

  task automatic t_overflow;
    int base = rx_cnt;
    set_en(1'b0);
    for (int i = 0; i < 16; i++) write_byte(8'(8'h40 + i));
    chk(overflow == 1'b0, "R8 no flag at 16", overflow, 0);
    write_byte(8'hEE);
    chk(overflow == 1'b1, "R8 flag on 17th", overflow, 1);
    set_en(1'b1);
    wait_rx(base + 16);
    wait_ticks(30);
    chk(rx_cnt == base + 16, "R8 17th dropped", rx_cnt, base + 16);
    for (int i = 0; i < 16; i++)
      chk(rx_buf[base+i] == 8'(8'h40 + i), "R8 stored data", rx_buf[base+i], 8'h40 + i);
    chk(overflow == 1'b1, "R8 sticky", overflow, 1);
    chk(fifo_empty == 1'b1, "R10 empty after drain", fifo_empty, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_burst();
    t_gate();
    t_overflow();
    chk(frame_err == 0, "R3 stop bits", frame_err, 0);
    chk(busy_err == 0, "R9 busy span", busy_err, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule